// File: doc/BRIEF.md
# Frame-Granular Input Port Selector

This block merges several switch input streams into one output stream and hands the output over one whole frame at a time. Each input port offers words with a valid flag and marks the first and last word of a frame with start-of-frame and end-of-frame flags. The selector keeps looking at every port for pending words. When it finds one, it grants that port and passes its words through to the output until the end-of-frame word has been transferred. Alongside each word it reports the index of the port it came from.

After every frame the grant is dropped, even if the same port has more data waiting. The selector then spends one cycle choosing again, in round-robin order, starting with the port after the one just served. As a result, a port never sends two frames back to back within one grant. A source has to let its port drop out of the grant and wait to be chosen again before it sends its next frame.

Both the inputs and the output use the valid/ready protocol. A word moves only in a cycle where valid and ready are both high. The output's valid, data and frame markers come combinationally from the granted port. The output ready signal is passed back only to that port, so back-pressure on the output stalls the granted source in the same cycle. Every other port sees ready low, and a port must hold its word steady while its ready is low.

Top module: `frame_port_selector`

## Requirements
- R1: While reset is asserted and right after it, no port sees ready high and output valid is low.
- R2: When no grant is held, output valid is low and every input ready is low. With no port presenting valid, the block stays in this state cycle after cycle.
- R3: In a cycle with no grant held and at least one input valid, the block picks a port. It searches from the port after the one granted last (port 0 after reset), wraps from the highest index back to port 0, and skips ports whose valid is low. The picked index then appears on out_port for the whole grant.
- R4: The grant chosen in a selection cycle takes effect in the next cycle. During the selection cycle itself, no input ready is high.
- R5: While a grant is held, the granted port's ready equals out_ready, and every other port's ready is low.
- R6: While a grant is held, out_valid, out_data, out_sof and out_eof equal the granted port's in_valid, data word (bits p*DW to p*DW+DW-1 of in_data for port p), in_sof and in_eof, all in the same cycle.
- R7: A grant stays on the same port until a word with end-of-frame set is transferred. A stall with out_ready low, or a cycle where the granted port's valid is low, does not move the grant.
- R8: In the cycle after an end-of-frame word is transferred, no grant is held. Output valid and every input ready are low in that cycle.
- R9: If only one port has data, it is granted again after each one-cycle release, so it sends its frames one per grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NPORTS | Per-port word-valid flags |
| in_sof | input | NPORTS | Per-port start-of-frame markers |
| in_eof | input | NPORTS | Per-port end-of-frame markers |
| in_data | input | NPORTS*DW | Per-port data words, port p at bits p*DW and up |
| in_ready | output | NPORTS | Per-port ready; only the granted port can be high |
| out_valid | output | 1 | Output word valid |
| out_sof | output | 1 | Output start-of-frame marker |
| out_eof | output | 1 | Output end-of-frame marker |
| out_data | output | DW | Output data word |
| out_port | output | $clog2(NPORTS) | Index of the granted port |
| out_ready | input | 1 | Downstream ready |

## Verification
The bench builds the selector with its default three ports and an 8-bit data width. Three ports are enough to exercise a round-robin search that wraps from port 2 back to port 0 and one that skips over two idle ports. The narrow data width keeps the random words short, and a wrongly selected port still shows up in the data. Random gaps in valid and random output stalls test grant holding in the middle of a frame. A phase with a single busy port tests the forced release between back-to-back frames.

// File: rtl/frame_sel_pkg.sv
package frame_sel_pkg;
  typedef enum logic {
    SEL_IDLE = 1'b0,
    SEL_BUSY = 1'b1
  } sel_state_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/frame_rr_pick.sv
module frame_rr_pick #(
  parameter int NPORTS = 3,
  localparam int IW = frame_sel_pkg::idx_width(NPORTS)
) (
  input  logic [NPORTS-1:0] req,
  input  logic [IW-1:0]     last,
  output logic              found,
  output logic [IW-1:0]     pick
);
  int cand;

  // Scan from farthest to nearest so the nearest requester after 'last' wins.
  always_comb begin
    found = 1'b0;
    pick  = '0;
    cand  = 0;
    for (int k = NPORTS; k >= 1; k--) begin
      cand = (int'(last) + k) % NPORTS;
      if (req[cand]) begin
        found = 1'b1;
        pick  = IW'(cand);
      end
    end
  end
endmodule

// File: rtl/frame_port_mux.sv
module frame_port_mux #(
  parameter int NPORTS = 3,
  parameter int DW     = 32,
  localparam int IW = frame_sel_pkg::idx_width(NPORTS)
) (
  input  logic                 busy,
  input  logic [IW-1:0]        grant,
  input  logic [NPORTS-1:0]    in_valid,
  input  logic [NPORTS-1:0]    in_sof,
  input  logic [NPORTS-1:0]    in_eof,
  input  logic [NPORTS*DW-1:0] in_data,
  input  logic                 out_ready,
  output logic [NPORTS-1:0]    in_ready,
  output logic                 out_valid,
  output logic                 out_sof,
  output logic                 out_eof,
  output logic [DW-1:0]        out_data
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_ready
    assign in_ready[p] = busy && (grant == IW'(p)) && out_ready;
  end

  always_comb begin
    out_valid = busy && in_valid[grant];
    out_sof   = in_sof[grant];
    out_eof   = in_eof[grant];
    out_data  = in_data[grant*DW +: DW];
  end
endmodule

// File: rtl/frame_port_selector.sv
module frame_port_selector #(
  parameter int NPORTS = 3,
  parameter int DW     = 32,
  localparam int IW = frame_sel_pkg::idx_width(NPORTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORTS-1:0]    in_valid,
  input  logic [NPORTS-1:0]    in_sof,
  input  logic [NPORTS-1:0]    in_eof,
  input  logic [NPORTS*DW-1:0] in_data,
  output logic [NPORTS-1:0]    in_ready,
  output logic                 out_valid,
  output logic                 out_sof,
  output logic                 out_eof,
  output logic [DW-1:0]        out_data,
  output logic [IW-1:0]        out_port,
  input  logic                 out_ready
);
  import frame_sel_pkg::*;

  sel_state_e    state;
  logic [IW-1:0] grant;
  logic [IW-1:0] last;
  logic          found;
  logic [IW-1:0] pick;
  logic          busy;
  logic          frame_done;

  frame_rr_pick #(.NPORTS(NPORTS)) u_pick (
    .req   (in_valid),
    .last  (last),
    .found (found),
    .pick  (pick)
  );

  assign busy = (state == SEL_BUSY);

  frame_port_mux #(.NPORTS(NPORTS), .DW(DW)) u_mux (
    .busy      (busy),
    .grant     (grant),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_eof    (in_eof),
    .in_data   (in_data),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_eof   (out_eof),
    .out_data  (out_data)
  );

  assign frame_done = out_valid && out_ready && out_eof;
  assign out_port   = grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SEL_IDLE;
      grant <= '0;
      last  <= IW'(NPORTS - 1);
    end else begin
      case (state)
        SEL_IDLE: if (found) begin
          state <= SEL_BUSY;
          grant <= pick;
        end
        SEL_BUSY: if (frame_done) begin
          state <= SEL_IDLE;
          last  <= grant;
        end
        default: state <= SEL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frame_port_selector_chk.sv
module frame_port_selector_chk #(
  parameter int NPORTS = 3,
  parameter int DW     = 32,
  localparam int IW = frame_sel_pkg::idx_width(NPORTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPORTS-1:0] in_ready,
  input logic              out_valid,
  input logic              out_eof,
  input logic [IW-1:0]     out_port,
  input logic              out_ready
);
  a_r5_single_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready));

  a_r5_ready_from_output: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_ready) |-> out_ready);

  a_r6_transfer_on_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> in_ready[out_port]);

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_port));

  a_r7_hold_mid_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_eof) |=> $stable(out_port));

  a_r8_release_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_eof) |=> (in_ready == '0 && !out_valid));
endmodule

bind frame_port_selector frame_port_selector_chk #(.NPORTS(NPORTS), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_eof   (out_eof),
  .out_port  (out_port),
  .out_ready (out_ready)
);

// File: tb/frame_port_selector_tb.sv
module frame_port_selector_tb;
  localparam int NP = 3;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] in_valid, in_sof, in_eof, in_ready;
  logic [NP*DW-1:0] in_data;
  logic          out_valid, out_sof, out_eof, out_ready;
  logic [DW-1:0] out_data;
  logic [1:0]    out_port;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  frame_port_selector #(.NPORTS(NP), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
    .out_data(out_data), .out_port(out_port), .out_ready(out_ready)
  );

  // Source state per port
  int rem [NP];
  int gap [NP];
  bit first [NP];
  bit en [NP];
  int drop_pct, stall_pct, gap_max;

  // Reference model state
  bit m_busy, m_first;
  int m_g, m_last;
  bit prev_eof_fire, prev_stall;
  int grants_p1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int rr_pick(input int last, input logic [NP-1:0] v);
    for (int k = 1; k <= NP; k++) begin
      if (v[(last + k) % NP]) return (last + k) % NP;
    end
    return -1;
  endfunction

  task automatic drive_inputs();
    for (int p = 0; p < NP; p++) begin
      if (rem[p] == 0 && gap[p] == 0 && en[p]) begin
        rem[p] = 1 + int'($urandom % 4);
        first[p] = 1'b1;
      end
      in_valid[p] = (rem[p] > 0) && (int'($urandom % 100) >= drop_pct);
      in_sof[p]   = first[p];
      in_eof[p]   = (rem[p] == 1);
      in_data[p*DW +: DW] = DW'($urandom);
    end
    out_ready = (int'($urandom % 100) >= stall_pct);
  endtask

  task automatic check_and_step();
    logic [NP-1:0] exp_ready;
    bit fire_eof, stall;
    int pk;
    if (!m_busy) begin
      chk(out_valid == 1'b0, prev_eof_fire ? "R8" : "R2", out_valid, 0);
      chk(in_ready == '0, prev_eof_fire ? "R8" : ((|in_valid) ? "R4" : "R2"), in_ready, 0);
    end else begin
      exp_ready = out_ready ? NP'(1 << m_g) : '0;
      chk(in_ready == exp_ready, m_first ? "R4" : "R5", in_ready, exp_ready);
      chk(out_valid == in_valid[m_g], "R6", out_valid, in_valid[m_g]);
      if (in_valid[m_g]) begin
        chk(out_data == in_data[m_g*DW +: DW], "R6", out_data, in_data[m_g*DW +: DW]);
        chk({out_sof, out_eof} == {in_sof[m_g], in_eof[m_g]}, "R6", {out_sof, out_eof}, {in_sof[m_g], in_eof[m_g]});
      end
      chk(int'(out_port) == m_g, m_first ? "R3" : (prev_stall ? "R7" : "R7"), out_port, m_g);
    end
    // Source handshakes
    for (int p = 0; p < NP; p++) begin
      if (m_busy && p == m_g && in_valid[p] && out_ready) begin
        rem[p]--;
        first[p] = 1'b0;
        if (rem[p] == 0) gap[p] = (gap_max > 0) ? int'($urandom % (gap_max + 1)) : 0;
      end else if (rem[p] == 0 && gap[p] > 0) begin
        gap[p]--;
      end
    end
    // Model update
    fire_eof = m_busy && in_valid[m_g] && out_ready && in_eof[m_g];
    stall    = m_busy && in_valid[m_g] && !out_ready;
    m_first  = 1'b0;
    if (!m_busy) begin
      pk = rr_pick(m_last, in_valid);
      if (pk >= 0) begin
        m_busy = 1'b1; m_g = pk; m_first = 1'b1;
        if (pk == 1) grants_p1++;
      end
    end else if (fire_eof) begin
      m_busy = 1'b0; m_last = m_g;
    end
    prev_eof_fire = fire_eof;
    prev_stall = stall;
  endtask

  task automatic run(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      drive_inputs();
      #1;
      check_and_step();
    end
  endtask

  initial begin
    #(20 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; in_valid = '0; in_sof = '0; in_eof = '0; in_data = '0; out_ready = 1'b1;
    for (int p = 0; p < NP; p++) begin rem[p] = 0; gap[p] = 0; first[p] = 0; en[p] = 0; end
    m_busy = 0; m_first = 0; m_g = 0; m_last = NP - 1; prev_eof_fire = 0; prev_stall = 0;
    grants_p1 = 0;
    drop_pct = 0; stall_pct = 0; gap_max = 0;
    in_valid = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready == '0, "R1", in_ready, 0);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    in_valid = '0;
    rst_n = 1'b1;
    #1;
    chk(in_ready == '0 && !out_valid, "R1", {in_ready, out_valid}, 0);

    // Idle: no data anywhere
    run(10);

    // Single port with continuous frames: forced release between frames
    en[1] = 1; stall_pct = 0; drop_pct = 0; gap_max = 0;
    grants_p1 = 0;
    run(40);
    chk(grants_p1 >= 5, "R9", grants_p1, 5);
    en[1] = 0;
    run(12);

    // All ports loaded, no gaps: strict rotation with wrap
    en[0] = 1; en[1] = 1; en[2] = 1;
    run(80);

    // Random mix with dropouts, stalls and gaps
    drop_pct = 25; stall_pct = 30; gap_max = 4;
    run(1500);
    en[0] = 0; en[2] = 0; drop_pct = 10; stall_pct = 50;
    run(300);
    en[0] = 1; en[2] = 1; en[1] = 0; drop_pct = 40; stall_pct = 20; gap_max = 6;
    run(800);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule